// File: doc/BRIEF.md
# USB device event interrupt register

This block is the event and interrupt control register of a USB device controller. The bus logic sends three kinds of host event as single-cycle pulses: bus reset, suspend and resume. The block catches each one in a sticky request bit. Each request has a mask, and the block merges the requests that are not masked into one registered interrupt line. The same register holds the controller enable bit and shows the live bus-activity status.

Software accesses the register through a simple port: a write strobe, a 32-bit write bus and a read bus that always returns the current contents. Address decoding belongs to the surrounding register map. A host bus reset clears the suspend and resume requests and sets the reset request. The reset request keeps that value, so software can see afterwards that the reset happened. A core reset returns every field to its default value.

Top module: `usbdev_evt_intreg`

## Requirements
- R1: After a core reset (`rst` high at a clock edge), the register reads 0x000000A0: only the reset mask (bit 7) and the suspend/resume mask (bit 5) are 1. `irq` and `ctrl_enable` are 0.
- R2: Bit 0 is the enable bit and can be read and written. `ctrl_enable` equals bit 0. Writes to bits 31:8 are ignored, and these bits always read 0.
- R3: Bit 1 reads the value `bus_active` had at the previous clock edge. Writes to bit 1 are ignored.
- R4: A pulse on `ev_suspend`, `ev_resume` or `ev_bus_reset` sets bit 4, bit 3 or bit 6 respectively at that edge. This happens whether or not the bit's mask is set.
- R5: Writing 1 to bit 3, 4 or 6 clears it, and writing 0 leaves it unchanged. Writes to the mask bits 2, 5 and 7 take effect without changing any request bit.
- R6: If a set event and a write-1-to-clear reach the same request bit in the same cycle, the bit ends up set.
- R7: An `ev_bus_reset` pulse sets bit 6 and clears bits 3 and 4, even if a suspend or resume pulse arrives in the same cycle. It leaves the enable bit and the mask bits unchanged.
- R8: `irq` is registered. At each edge it takes the value (bit6 & ~bit7) | (bit4 & ~bit5) | (bit3 & ~bit5 & ~bit2), using the register contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high core reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| ev_bus_reset | input | 1 | Host bus reset pulse |
| ev_suspend | input | 1 | Host suspend pulse |
| ev_resume | input | 1 | Host resume pulse |
| bus_active | input | 1 | Bus activity level from the bus logic |
| ctrl_enable | output | 1 | Controller enable (bit 0) |
| irq | output | 1 | Merged interrupt request |

## Verification
A write or event that is applied before an edge shows up in `rd_data` and `ctrl_enable` right after that edge. `irq` follows one edge later, because it is registered from the state held before the edge. The bench drives inputs on the falling edge and lets one rising edge pass. It then updates its own model: the new expected interrupt comes from the old expected register value, and the new expected register value comes from the inputs. All three outputs are compared on the next falling edge. This spacing checks both the one-cycle register latency and the extra cycle of interrupt latency on every step.

// File: rtl/usbdev_evt_pkg.sv
package usbdev_evt_pkg;

    localparam int REG_W = 8;
    localparam int N_REQ = 3;

    // request slot indices
    localparam int REQ_RST  = 0;
    localparam int REQ_SUSP = 1;
    localparam int REQ_RES  = 2;

    // field positions that software decodes
    localparam int BIT_EN   = 0;
    localparam int BIT_ACT  = 1;
    localparam int BIT_RESM = 2;
    localparam int BIT_RES  = 3;
    localparam int BIT_SUSP = 4;
    localparam int BIT_SRM  = 5;
    localparam int BIT_RST  = 6;
    localparam int BIT_RSTM = 7;

    typedef struct packed {
        logic rst_mask;
        logic rst_req;
        logic sr_mask;
        logic susp_req;
        logic res_req;
        logic res_mask;
        logic active;
        logic enable;
    } evt_reg_t;

    localparam evt_reg_t CORE_RST_VAL = '{rst_mask: 1'b1, sr_mask: 1'b1, default: 1'b0};

    function automatic int req_pos(input int idx);
        case (idx)
            REQ_RST:  return BIT_RST;
            REQ_SUSP: return BIT_SUSP;
            default:  return BIT_RES;
        endcase
    endfunction

endpackage

// File: rtl/usbdev_evt_req.sv
module usbdev_evt_req (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic flush_i,
    output logic q
);
    // priority: core reset, bus-reset flush, hardware set, software clear
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (flush_i) q <= 1'b0;
        else if (set_i)   q <= 1'b1;
        else if (clr_i)   q <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i && !flush_i) |=> q);
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i && !flush_i) |=> !q);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i && !flush_i) |=> $stable(q));
    a_r7_flush: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !q);
endmodule

// File: rtl/usbdev_evt_irq.sv
module usbdev_evt_irq #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] open_i,
    output logic             irq
);
    logic [N_SRC-1:0] live;
    assign live = req_i & open_i;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |live;
    end

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> !irq);
endmodule

// File: rtl/usbdev_evt_intreg.sv
module usbdev_evt_intreg
    import usbdev_evt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_bus_reset,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              bus_active,
    output logic              ctrl_enable,
    output logic              irq
);
    localparam int RSV_W = DATA_W - REG_W;

    evt_reg_t         st;
    logic [N_REQ-1:0] set_v, clr_v, flush_v, req_v, open_v;
    logic             en_q, act_q, resm_q, srm_q, rstm_q;
    logic             rsv_unused;

    assign rsv_unused = ^wr_data[DATA_W-1:REG_W];

    // configuration and status fields
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= CORE_RST_VAL.enable;
            act_q  <= CORE_RST_VAL.active;
            resm_q <= CORE_RST_VAL.res_mask;
            srm_q  <= CORE_RST_VAL.sr_mask;
            rstm_q <= CORE_RST_VAL.rst_mask;
        end else begin
            act_q <= bus_active;
            if (wr_en) begin
                en_q   <= wr_data[BIT_EN];
                resm_q <= wr_data[BIT_RESM];
                srm_q  <= wr_data[BIT_SRM];
                rstm_q <= wr_data[BIT_RSTM];
            end
        end
    end

    // event sources per request slot
    assign set_v[REQ_RST]    = ev_bus_reset;
    assign set_v[REQ_SUSP]   = ev_suspend;
    assign set_v[REQ_RES]    = ev_resume;
    assign flush_v[REQ_RST]  = 1'b0;
    assign flush_v[REQ_SUSP] = ev_bus_reset;
    assign flush_v[REQ_RES]  = ev_bus_reset;

    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_req
            localparam int POS = req_pos(g);
            assign clr_v[g] = wr_en & wr_data[POS];
            usbdev_evt_req i_req (
                .clk    (clk),
                .rst    (rst),
                .set_i  (set_v[g]),
                .clr_i  (clr_v[g]),
                .flush_i(flush_v[g]),
                .q      (req_v[g])
            );
        end
    endgenerate

    assign st.enable   = en_q;
    assign st.active   = act_q;
    assign st.res_mask = resm_q;
    assign st.res_req  = req_v[REQ_RES];
    assign st.susp_req = req_v[REQ_SUSP];
    assign st.sr_mask  = srm_q;
    assign st.rst_req  = req_v[REQ_RST];
    assign st.rst_mask = rstm_q;

    assign open_v[REQ_RST]  = ~rstm_q;
    assign open_v[REQ_SUSP] = ~srm_q;
    assign open_v[REQ_RES]  = ~srm_q & ~resm_q;

    usbdev_evt_irq #(.N_SRC(N_REQ)) i_irq (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_v),
        .open_i(open_v),
        .irq   (irq)
    );

    assign rd_data     = {{RSV_W{1'b0}}, st};
    assign ctrl_enable = en_q;

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (rd_data == DATA_W'(CORE_RST_VAL)) && !irq);
    a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ctrl_enable == $past(wr_data[BIT_EN]));
    a_r3_active_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_data[BIT_ACT] == $past(bus_active));
    a_r7_bus_reset: assert property (@(posedge clk) disable iff (rst)
        ev_bus_reset |=> rd_data[BIT_RST] && !rd_data[BIT_SUSP] && !rd_data[BIT_RES]);
    a_r8_reset_irq: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_RST] && !rd_data[BIT_RSTM]) |=> irq);
endmodule

// File: tb/test_usbdev_evt_intreg.sv
`timescale 1ns/1ps
module test_usbdev_evt_intreg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_bus_reset = 1'b0, ev_suspend = 1'b0, ev_resume = 1'b0;
    logic        bus_active = 1'b0;
    logic        ctrl_enable, irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_reg;
    logic       exp_irq;

    always #10 clk = ~clk;

    usbdev_evt_intreg i_usbdev_evt_intreg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend), .ev_resume(ev_resume),
        .bus_active(bus_active), .ctrl_enable(ctrl_enable), .irq(irq)
    );

    function automatic logic irq_of(input logic [7:0] s);
        return (s[6] & ~s[7]) | (s[4] & ~s[5]) | (s[3] & ~s[5] & ~s[2]);
    endfunction

    function automatic logic [7:0] next_of(input logic [7:0] s, input logic w,
            input logic [31:0] d, input logic br, input logic su, input logic re,
            input logic act);
        logic [7:0] n = s;
        if (w) begin
            n[0] = d[0]; n[2] = d[2]; n[5] = d[5]; n[7] = d[7];
            if (d[3]) n[3] = 1'b0;
            if (d[4]) n[4] = 1'b0;
            if (d[6]) n[6] = 1'b0;
        end
        n[1] = act;
        if (su) n[4] = 1'b1;
        if (re) n[3] = 1'b1;
        if (br) begin n[6] = 1'b1; n[4] = 1'b0; n[3] = 1'b0; end
        return n;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (rd_data !== {24'h0, exp_reg}) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, {24'h0, exp_reg});
        end
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
        end
        checks++;
        if (ctrl_enable !== exp_reg[0]) begin
            errors++;
            $display("FAIL %s ctrl_enable actual=%b expected=%b", tag, ctrl_enable, exp_reg[0]);
        end
    endtask

    // called at a falling edge: drive, pass one rising edge, check at next falling edge
    task automatic step(input logic w, input logic [31:0] d, input logic br,
            input logic su, input logic re, input logic act, input string tag);
        wr_en = w; wr_data = d; ev_bus_reset = br; ev_suspend = su;
        ev_resume = re; bus_active = act;
        @(posedge clk);
        exp_irq = irq_of(exp_reg);
        exp_reg = next_of(exp_reg, w, d, br, su, re, act);
        @(negedge clk);
        wr_en = 1'b0; ev_bus_reset = 1'b0; ev_suspend = 1'b0; ev_resume = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_reg = 8'hA0; exp_irq = 1'b0;
        check_all("R1 reset value");

        // R2 enable and reserved bits (masks stay set)
        step(1, 32'hFFFF_FFA1, 0, 0, 0, 0, "R2 enable write, reserved ignored");
        step(1, 32'h5A5A_5AA0, 0, 0, 0, 0, "R2 enable clear");
        // R3 active status follows input, write ignored
        step(0, 0, 0, 0, 0, 1, "R3 active follows");
        step(1, 32'h0000_00A0, 0, 0, 0, 0, "R3 active write ignored");
        // R4 events set while masked, no irq
        step(0, 0, 0, 1, 0, 0, "R4 suspend masked sets");
        step(0, 0, 0, 0, 1, 0, "R4 resume masked sets");
        step(0, 0, 0, 0, 0, 0, "R8 masked no irq");
        // R5 W0 no effect, mask write keeps requests
        step(1, 32'h0000_0000, 0, 0, 0, 0, "R5 mask clear keeps requests");
        step(0, 0, 0, 0, 0, 0, "R8 irq from unmasked suspend");
        step(1, 32'h0000_0010, 0, 0, 0, 0, "R5 w1c suspend");
        step(1, 32'h0000_0004, 0, 0, 0, 0, "R8 resume mask silences resume");
        step(0, 0, 0, 0, 0, 0, "R8 resume masked irq low");
        step(1, 32'h0000_0008, 0, 0, 0, 0, "R5 w1c resume");
        // R6 set wins over clear
        step(1, 32'h0000_0018, 0, 1, 1, 0, "R6 set wins");
        // R7 bus reset clears suspend/resume even with same-cycle event
        step(1, 32'h0000_0001, 1, 1, 1, 0, "R7 bus reset wins, config kept");
        step(0, 0, 0, 0, 0, 0, "R8 reset request irq");
        step(1, 32'h0000_0081, 0, 0, 0, 0, "R8 reset mask silences");
        step(1, 32'h0000_00C0, 1, 0, 0, 0, "R6 bus reset vs w1c");
        step(1, 32'h0000_0040, 0, 0, 0, 0, "R5 w1c reset request");

        for (int i = 0; i < 3000; i++) begin
            logic w, br, su, re, act;
            logic [31:0] d;
            w   = ($urandom % 4) == 0;
            d   = $urandom;
            br  = ($urandom % 32) == 0;
            su  = ($urandom % 8) == 0;
            re  = ($urandom % 8) == 0;
            act = $urandom % 2;
            step(w, d, br, su, re, act, "R8 random mix");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule